// File: doc/BRIEF.md
# Programmable Periodic Interrupt Rate Generator

This block produces periodic interrupt ticks for a real-time-clock style register file. A 32.768 kHz time base reaches it as a single-cycle enable strobe in the system clock domain. A 4-bit exponent code picks how many of those strobes make up one tick period: code 0 turns the generator off, and a nonzero code n gives 32768 / 2^(n-1) ticks per second. A separate enable pin gates the ticks. For each tick the block raises a one-cycle pulse, together with the flag-set mask that the surrounding status register ORs into its interrupt status byte.

The register file owns storage and clear-on-read. This block only sees the current rate code, the enable bit and a strobe that marks each write to the rate register. A change of the code, a change of the enable, or any write to the rate register (even one that rewrites the same value) restarts the divider. The first tick after a restart therefore comes one full period later. There is no data stream here: every pin is a plain level or strobe, so no valid/ready handshake or back-pressure applies.

Top module: `prate_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `tick_o` is 0 and `set_mask_o` is 0x00.
- R2: With `rate_sel_i` equal to 0, no tick is produced, whatever the enable and strobe inputs.
- R3: With `pie_i` low, no tick is produced, whatever the rate code and strobe inputs.
- R4: With `pie_i` high and a nonzero code n held steady, a tick follows every 2^(n-1)-th `base_stb_i` pulse, counted from the restart. Clock cycles without a strobe do not advance the count. `tick_o` goes high in the cycle after the clock edge that samples the completing strobe.
- R5: `set_mask_o` equals 0xC0 (bit 7 interrupt-request flag, bit 6 periodic flag) in exactly the cycles where `tick_o` is 1, and is 0x00 in every other cycle.
- R6: At any clock edge where `rate_sel_i` differs from its value at the previous edge, the divider restarts from zero. A strobe at that edge is not counted and cannot complete a tick.
- R7: At any clock edge where `rate_wr_i` is 1, the divider restarts in the same way as in R6, even if the code is unchanged.
- R8: At any clock edge where `pie_i` differs from its value at the previous edge, the divider restarts. After a rise, the first tick comes one full period later. From the edge of a fall on, no strobe produces a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_stb_i | input | 1 | One-cycle strobe at the 32.768 kHz time-base rate |
| rate_sel_i | input | 4 | Rate exponent code; 0 = off, n = 32768/2^(n-1) Hz |
| rate_wr_i | input | 1 | Pulses on every write to the rate register |
| pie_i | input | 1 | Periodic interrupt enable |
| tick_o | output | 1 | One-cycle pulse per periodic tick |
| set_mask_o | output | 8 | Flag bits to OR into the interrupt status byte (0xC0 on a tick) |

## Verification
A divider count that is stale or misloaded after a restart shows as a tick that comes early or late. The error surfaces at the first tick after the restart, within one programmed period. A wrong terminal-count decode shifts every period for that code, so the scoreboard flags the very first tick of a steady run. Faulty gating or restart detection shows as a tick in a cycle where none is queued, one cycle after the offending strobe. The full-range code 15 and back-to-back ticks at code 1 cover both ends of the counter width.

// File: rtl/prate_pkg.sv
package prate_pkg;

  // Status-byte positions that a tick asks the register file to set.
  localparam int IRQ_FLAG_BIT = 7;
  localparam int PER_FLAG_BIT = 6;

  // Divider terminal count for exponent code `code`: 2^(code-1) - 1.
  function automatic int unsigned term_for_code(input int unsigned code);
    if (code == 0) return 0;
    return (1 << (code - 1)) - 1;
  endfunction

endpackage

// File: rtl/prate_decode.sv
module prate_decode #(
  parameter int SEL_W = 4,
  parameter int CNT_W = 14
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pie_i,
  output logic             active_o,
  output logic [CNT_W-1:0] term_o
);
  import prate_pkg::*;

  localparam int NUM_CODES = 1 << SEL_W;

  // One compare per nonzero code, each with a precomputed terminal count.
  logic [CNT_W-1:0] term_tbl [NUM_CODES];

  genvar g;
  generate
    for (g = 0; g < NUM_CODES; g++) begin : g_term
      assign term_tbl[g] = CNT_W'(term_for_code(g));
    end
  endgenerate

  always_comb begin
    term_o = '0;
    for (int i = 1; i < NUM_CODES; i++) begin
      if (sel_i == SEL_W'(i)) term_o = term_tbl[i];
    end
  end

  assign active_o = pie_i && (sel_i != '0);

endmodule

// File: rtl/prate_restart.sv
module prate_restart #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pie_i,
  input  logic             wr_i,
  output logic             restart_o
);
  logic [SEL_W-1:0] sel_q;
  logic             pie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      pie_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      pie_q <= pie_i;
    end
  end

  assign restart_o = wr_i || (sel_i != sel_q) || (pie_i != pie_q);

endmodule

// File: rtl/prate_divider.sv
module prate_divider #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             stb_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  assign at_term = (cnt_q == term_i);
  assign hit_o   = run_i && !clear_i && stb_i && at_term;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i || !run_i) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      cnt_q <= at_term ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/prate_gen.sv
module prate_gen #(
  parameter int SEL_W  = 4,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_stb_i,
  input  logic [SEL_W-1:0]  rate_sel_i,
  input  logic              rate_wr_i,
  input  logic              pie_i,
  output logic              tick_o,
  output logic [FLAG_W-1:0] set_mask_o
);
  import prate_pkg::*;

  // Largest exponent is (2^SEL_W - 2), so that many counter bits suffice.
  localparam int CNT_W = (1 << SEL_W) - 2;
  localparam logic [FLAG_W-1:0] TICK_MASK =
    FLAG_W'((1 << IRQ_FLAG_BIT) | (1 << PER_FLAG_BIT));

  logic             active_w;
  logic [CNT_W-1:0] term_w;
  logic             restart_w;
  logic             hit_w;
  logic [CNT_W-1:0] cnt_w;

  prate_decode #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_dec (
    .sel_i    (rate_sel_i),
    .pie_i    (pie_i),
    .active_o (active_w),
    .term_o   (term_w)
  );

  prate_restart #(.SEL_W(SEL_W)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (rate_sel_i),
    .pie_i     (pie_i),
    .wr_i      (rate_wr_i),
    .restart_o (restart_w)
  );

  prate_divider #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (restart_w),
    .run_i   (active_w),
    .stb_i   (base_stb_i),
    .term_i  (term_w),
    .hit_o   (hit_w),
    .cnt_o   (cnt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_o     <= 1'b0;
      set_mask_o <= '0;
    end else begin
      tick_o     <= hit_w;
      set_mask_o <= hit_w ? TICK_MASK : '0;
    end
  end

endmodule

// File: rtl/prate_checker.sv
module prate_checker #(
  parameter int SEL_W  = 4,
  parameter int FLAG_W = 8,
  parameter int CNT_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base_stb_i,
  input logic [SEL_W-1:0]  rate_sel_i,
  input logic              rate_wr_i,
  input logic              pie_i,
  input logic              tick_o,
  input logic [FLAG_W-1:0] set_mask_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  term_i
);

  a_r2_zero_rate_silent: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(rate_sel_i) != '0);

  a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(pie_i));

  a_r4_tick_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(base_stb_i));

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pie_i && rate_sel_i != '0 && $stable(rate_sel_i)) |-> cnt_i <= term_i);

  a_r5_mask_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> set_mask_o == FLAG_W'(8'hC0));

  a_r5_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> set_mask_o == '0);

  a_r6_rate_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel_i != $past(rate_sel_i)) |=> !tick_o);

  a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr_i |=> !tick_o);

  a_r8_enable_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (pie_i != $past(pie_i)) |=> !tick_o);

endmodule

bind prate_gen prate_checker #(
  .SEL_W (SEL_W),
  .FLAG_W(FLAG_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_stb_i (base_stb_i),
  .rate_sel_i (rate_sel_i),
  .rate_wr_i  (rate_wr_i),
  .pie_i      (pie_i),
  .tick_o     (tick_o),
  .set_mask_o (set_mask_o),
  .cnt_i      (cnt_w),
  .term_i     (term_w)
);

// File: tb/tb_prate_gen.sv
module tb_prate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_stb_i = 1'b0;
  logic [3:0] rate_sel_i = '0;
  logic       rate_wr_i = 1'b0;
  logic       pie_i = 1'b0;
  logic       tick_o;
  logic [7:0] set_mask_o;

  prate_gen dut (
    .clk(clk), .rst_n(rst_n), .base_stb_i(base_stb_i),
    .rate_sel_i(rate_sel_i), .rate_wr_i(rate_wr_i), .pie_i(pie_i),
    .tick_o(tick_o), .set_mask_o(set_mask_o)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    tick_tally = 0;
  int    exp_q[$];
  string phase = "R1";
  bit    done = 1'b0;

  // Spec model state
  logic [3:0] m_prev_sel = '0;
  logic       m_prev_pie = 1'b0;
  int         m_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // Driver: apply one cycle of inputs and queue the expected tick.
  task automatic step(input logic [3:0] sel, input logic pie, input logic wr,
                      input logic stb);
    bit restart, active, hit;
    int term;
    @(negedge clk);
    rate_sel_i = sel; pie_i = pie; rate_wr_i = wr; base_stb_i = stb;
    restart = (sel != m_prev_sel) || (pie != m_prev_pie) || wr;
    active  = pie && (sel != 0);
    term    = (sel == 0) ? 0 : (1 << (sel - 1)) - 1;
    hit     = 1'b0;
    if (restart || !active) m_cnt = 0;
    else if (stb) begin
      if (m_cnt == term) begin hit = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end
    if (hit) exp_q.push_back(cyc + 1);
    m_prev_sel = sel; m_prev_pie = pie;
  endtask

  // Monitor: compare each cycle against the scoreboard queue.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && !done) begin
        bit exp_now;
        exp_now = (exp_q.size() > 0) && (exp_q[0] == cyc);
        if (exp_now) void'(exp_q.pop_front());
        chk(phase, int'(tick_o), int'(exp_now));
        chk("R5 mask", int'(set_mask_o), exp_now ? 32'hC0 : 0);
        if (tick_o) tick_tally++;
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 tick in reset", int'(tick_o), 0);
    chk("R1 mask in reset", int'(set_mask_o), 0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R1 tick after reset", int'(tick_o), 0);
    chk("R1 mask after reset", int'(set_mask_o), 0);
    for (int i = 0; i < 10; i++) step(4'd0, 1'b0, 1'b0, 1'b1);

    // R2: rate code 0 with enable high
    phase = "R2";
    t0 = tick_tally;
    for (int i = 0; i < 60; i++) step(4'd0, 1'b1, 1'b0, 1'b1);
    step(4'd0, 1'b1, 1'b0, 1'b0);
    chk("R2 ticks with code 0", tick_tally - t0, 0);

    // R3: enable low with nonzero code
    phase = "R3";
    t0 = tick_tally;
    for (int i = 0; i < 60; i++) step(4'd3, 1'b0, 1'b0, 1'b1);
    step(4'd3, 1'b0, 1'b0, 1'b0);
    chk("R3 ticks while disabled", tick_tally - t0, 0);

    // R4: code 1, strobe every cycle -> tick per strobe
    phase = "R4";
    step(4'd1, 1'b1, 1'b0, 1'b0);
    t0 = tick_tally;
    for (int i = 0; i < 20; i++) step(4'd1, 1'b1, 1'b0, 1'b1);
    step(4'd1, 1'b1, 1'b0, 1'b0);
    step(4'd1, 1'b1, 1'b0, 1'b0);
    chk("R4 code1 tick count", tick_tally - t0, 20);

    // R4: code 3, strobe every third cycle, 40 strobes -> 10 ticks
    step(4'd3, 1'b1, 1'b0, 1'b0);
    t0 = tick_tally;
    for (int i = 0; i < 120; i++) step(4'd3, 1'b1, 1'b0, (i % 3) == 2);
    step(4'd3, 1'b1, 1'b0, 1'b0);
    step(4'd3, 1'b1, 1'b0, 1'b0);
    chk("R4 code3 tick count", tick_tally - t0, 10);

    // R4: code 6, irregular strobe gaps, 96 strobes -> 3 ticks
    step(4'd6, 1'b1, 1'b0, 1'b0);
    t0 = tick_tally;
    for (int i = 0; i < 96; i++) begin
      for (int k = 0; k < (i % 4); k++) step(4'd6, 1'b1, 1'b0, 1'b0);
      step(4'd6, 1'b1, 1'b0, 1'b1);
    end
    step(4'd6, 1'b1, 1'b0, 1'b0);
    step(4'd6, 1'b1, 1'b0, 1'b0);
    chk("R4 code6 tick count", tick_tally - t0, 3);

    // R4: code 15, full counter width, 2^15 strobes -> 2 ticks
    step(4'd15, 1'b1, 1'b0, 1'b0);
    t0 = tick_tally;
    for (int i = 0; i < 32768; i++) step(4'd15, 1'b1, 1'b0, 1'b1);
    step(4'd15, 1'b1, 1'b0, 1'b0);
    step(4'd15, 1'b1, 1'b0, 1'b0);
    chk("R4 code15 tick count", tick_tally - t0, 2);

    // R6: change code mid-period, with a strobe on the change edge
    phase = "R6";
    step(4'd4, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(4'd4, 1'b1, 1'b0, 1'b1);
    t0 = tick_tally;
    step(4'd5, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 15; i++) step(4'd5, 1'b1, 1'b0, 1'b1);
    step(4'd5, 1'b1, 1'b0, 1'b0);
    step(4'd5, 1'b1, 1'b0, 1'b0);
    chk("R6 no tick before new period", tick_tally - t0, 0);
    step(4'd5, 1'b1, 1'b0, 1'b1);
    step(4'd5, 1'b1, 1'b0, 1'b0);
    step(4'd5, 1'b1, 1'b0, 1'b0);
    chk("R6 tick after full new period", tick_tally - t0, 1);

    // R7: same-value write restarts the divider
    phase = "R7";
    step(4'd4, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) step(4'd4, 1'b1, 1'b0, 1'b1);
    t0 = tick_tally;
    step(4'd4, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) step(4'd4, 1'b1, 1'b0, 1'b1);
    step(4'd4, 1'b1, 1'b0, 1'b0);
    step(4'd4, 1'b1, 1'b0, 1'b0);
    chk("R7 write suppressed pending tick", tick_tally - t0, 0);
    step(4'd4, 1'b1, 1'b0, 1'b1);
    step(4'd4, 1'b1, 1'b0, 1'b0);
    step(4'd4, 1'b1, 1'b0, 1'b0);
    chk("R7 tick after full period", tick_tally - t0, 1);

    // R8: enable falls on a completing strobe, then rises again
    phase = "R8";
    step(4'd2, 1'b1, 1'b0, 1'b0);
    step(4'd2, 1'b1, 1'b0, 1'b1);
    t0 = tick_tally;
    step(4'd2, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) step(4'd2, 1'b0, 1'b0, 1'b1);
    step(4'd2, 1'b0, 1'b0, 1'b0);
    step(4'd2, 1'b0, 1'b0, 1'b0);
    chk("R8 no tick after enable falls", tick_tally - t0, 0);
    step(4'd2, 1'b1, 1'b0, 1'b1);
    step(4'd2, 1'b1, 1'b0, 1'b1);
    step(4'd2, 1'b1, 1'b0, 1'b0);
    step(4'd2, 1'b1, 1'b0, 1'b0);
    chk("R8 not early after enable rises", tick_tally - t0, 0);
    step(4'd2, 1'b1, 1'b0, 1'b1);
    step(4'd2, 1'b1, 1'b0, 1'b0);
    step(4'd2, 1'b1, 1'b0, 1'b0);
    chk("R8 tick one period after rise", tick_tally - t0, 1);

    step(4'd0, 1'b0, 1'b0, 1'b0);
    step(4'd0, 1'b0, 1'b0, 1'b0);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule